// File: doc/BRIEF.md
# PHY Bring-Up Register Sequencer

This block brings a serial-video PHY out of reset without software involvement. On a single-cycle start pulse it takes a snapshot of the per-mode settings: six PLL divider bytes, a pixel divider, a lock-detector clock divider and a 9-bit lock target code. It then drives a fixed, ordered series of byte writes onto a simple register bus. The series opens the mode sequence, replays a built-in table of common analog settings and loads the PLL dividers. It then packs the transmit-clock, lock-detector divider and lock target fields into their registers and closes the mode sequence. After that it polls the PHY status register until the PLL reports lock, or until a timeout built from a clock-frequency parameter runs out.

The bus carries one transfer per cycle. A write is a cycle with `bus_wr` high. A read is a cycle with `bus_rd` high, and the PHY returns the byte on `bus_rdata` in the cycle that follows. The register holding number n sits at byte address 4·n. When the sequence ends, `done` pulses for one cycle. `lock_error` rises together with that pulse when lock never came, and it stays high until the next accepted start.

Top module: `phy_cfg_seq`

## Requirements
- R1: While reset is held and after it is released, with no start, `bus_wr`, `bus_rd`, `done` and `lock_error` are all 0.
- R2: Register n has byte address 4·n. The first write after an accepted start goes to register 33 (address 0x84) with data 0x02, which has only the data-alignment bit 1 set.
- R3: Writes 2 to 39 replay the 38-entry common table in ascending register order: registers 0, 1, 8–11, 15–20 and 22–47. This includes register 1 = 0xD1, register 8 = 0x4F, register 11 = 0x65, register 41 = 0xE0 and register 45 = 0xF8, and the last table write is register 47 = 0x00.
- R4: Writes 40 to 45 put PLL divider byte i (`pll_div[8i+7:8i]`) into register 2+i, for i = 0..5.
- R5: Register 21 is written as 0x80 OR `pix_div`: transmit-clock invert in bit 7 and the pixel divider in bits 3:0.
- R6: Register 12 holds log2 of the one-hot `lkd_div` (1, 2, 4 or 8) in bits 5:4, with all other bits 0.
- R7: Register 13 holds `lock_tgt[7:0]`. Register 14 holds tolerance 2 in bits 7:4, code 2 in bits 3:1 and `lock_tgt[8]` in bit 0, so it reads 0x24 or 0x25.
- R8: Exactly 50 writes are issued on 50 consecutive cycles, with no read among them. The last write puts 0x82 (mode-done bit 7 plus bit 1) into register 33.
- R9: The first status read (address 0x88) comes in the cycle after the last write. Further reads are spaced exactly POLL_CYC = CLK_KHZ·POLL_US/1000 cycles apart.
- R10: When bit 6 (PLL lock) of the returned status byte is set, `done` pulses for one cycle, two cycles after that read strobe, with `lock_error` 0. With lock on the first read, `done` is high 52 cycles after the edge that samples start.
- R11: If MAX_POLLS = TIMEOUT_US/POLL_US reads all return lock clear, `done` pulses with `lock_error` = 1. `lock_error` holds until the next accepted start clears it. Lock seen on the last permitted read counts as success.
- R12: A start pulse during a running sequence is ignored. A start sampled in the cycle where `done` is high is accepted and begins a new full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up sequence (one-cycle pulse) |
| pll_div | input | 48 | Six PLL divider bytes, byte 0 in bits 7:0 |
| pix_div | input | 4 | Pixel divider field |
| lkd_div | input | 4 | One-hot lock-detector clock divider |
| lock_tgt | input | 9 | Lock-detector target code |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | 8 | Register byte address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |
| done | output | 1 | One-cycle end-of-sequence pulse |
| lock_error | output | 1 | Sequence ended without PLL lock |

## Verification
Two outcomes can meet on one status check: lock arriving on the very read that exhausts the poll budget. The bench provokes this with a PHY model that first reports lock on read MAX_POLLS. It then expects success, with `lock_error` low and the timeout latency. The second meeting point is a new start landing in the cycle of the `done` pulse. Here the bench raises start exactly in that cycle and expects a second complete 50-write sequence and a fresh lock result, while a start raised mid-sequence must leave the write count and the single `done` unchanged.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  localparam int BUS_AW   = 8;
  localparam int BUS_DW   = 8;
  localparam int N_COMMON = 38;
  localparam int N_PLL    = 6;

  // write program step layout (order is the bring-up sequence)
  localparam int STEP_OPEN  = 0;
  localparam int STEP_TBL0  = STEP_OPEN + 1;
  localparam int STEP_PLL0  = STEP_TBL0 + N_COMMON;
  localparam int STEP_TXCK  = STEP_PLL0 + N_PLL;
  localparam int STEP_LDIV  = STEP_TXCK + 1;
  localparam int STEP_TGLO  = STEP_LDIV + 1;
  localparam int STEP_TGHI  = STEP_TGLO + 1;
  localparam int STEP_CLOSE = STEP_TGHI + 1;
  localparam int N_STEPS    = STEP_CLOSE + 1;
  localparam int STEP_W     = $clog2(N_STEPS);

  localparam logic [5:0] RG_MODE = 6'd33;
  localparam logic [5:0] RG_STAT = 6'd34;
  localparam logic [5:0] RG_PLL0 = 6'd2;
  localparam logic [5:0] RG_TXCK = 6'd21;
  localparam logic [5:0] RG_LDIV = 6'd12;
  localparam logic [5:0] RG_TGLO = 6'd13;
  localparam logic [5:0] RG_TGHI = 6'd14;

  localparam int BIT_ALIGN = 1;
  localparam int BIT_MDONE = 7;
  localparam int BIT_LOCK  = 6;
  localparam int BIT_TXINV = 7;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WRITE,
    SQ_READ,
    SQ_CHECK,
    SQ_WAIT
  } sq_state_t;

  function automatic logic [BUS_AW-1:0] reg_addr(input logic [5:0] r);
    return {r, 2'b00};
  endfunction

  // table slot -> register number (skips the per-mode registers)
  function automatic logic [5:0] tbl_reg(input logic [5:0] i);
    if (i < 6'd2)       return i;
    else if (i < 6'd6)  return i + 6'd6;
    else if (i < 6'd12) return i + 6'd9;
    else                return i + 6'd10;
  endfunction

  function automatic logic [7:0] tbl_val(input logic [5:0] r);
    case (r)
      6'd1:    return 8'hD1;
      6'd8:    return 8'h4F;
      6'd9:    return 8'h30;
      6'd10:   return 8'h33;
      6'd11:   return 8'h65;
      6'd15:   return 8'h80;
      6'd16:   return 8'h6C;
      6'd17:   return 8'hF2;
      6'd18:   return 8'h67;
      6'd20:   return 8'h10;
      6'd22:   return 8'h30;
      6'd23:   return 8'h32;
      6'd24:   return 8'h60;
      6'd25:   return 8'h8F;
      6'd28:   return 8'h08;
      6'd33:   return 8'h80;
      6'd41:   return 8'hE0;
      6'd42:   return 8'h83;
      6'd43:   return 8'h0F;
      6'd44:   return 8'h3E;
      6'd45:   return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [1:0] div_log2(input logic [3:0] d);
    if (d[3])      return 2'd3;
    else if (d[2]) return 2'd2;
    else if (d[1]) return 2'd1;
    else           return 2'd0;
  endfunction

endpackage

// File: rtl/phy_cfg_rst_sync.sv
module phy_cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/phy_cfg_wr_prog.sv
module phy_cfg_wr_prog
  import phy_cfg_pkg::*;
(
  input  logic [STEP_W-1:0]     step,
  input  logic [8*N_PLL-1:0]    pll_div,
  input  logic [3:0]            pix_div,
  input  logic [3:0]            lkd_div,
  input  logic [8:0]            lock_tgt,
  output logic [BUS_AW-1:0]     addr,
  output logic [BUS_DW-1:0]     data
);

  logic [7:0] pll_byte [N_PLL];

  for (genvar g = 0; g < N_PLL; g++) begin : g_pll
    assign pll_byte[g] = pll_div[8*g +: 8];
  end

  logic [5:0] tbl_idx;
  logic [5:0] tbl_r;
  logic [2:0] pll_idx;

  assign tbl_idx = 6'(step - STEP_W'(STEP_TBL0));
  assign tbl_r   = tbl_reg(tbl_idx);
  assign pll_idx = 3'(step - STEP_W'(STEP_PLL0));

  always_comb begin
    addr = '0;
    data = '0;
    if (step == STEP_W'(STEP_OPEN)) begin
      addr = reg_addr(RG_MODE);
      data = 8'(1 << BIT_ALIGN);
    end else if (step < STEP_W'(STEP_PLL0)) begin
      addr = reg_addr(tbl_r);
      data = tbl_val(tbl_r);
    end else if (step < STEP_W'(STEP_TXCK)) begin
      addr = reg_addr(RG_PLL0 + 6'(pll_idx));
      data = pll_byte[pll_idx];
    end else if (step == STEP_W'(STEP_TXCK)) begin
      addr = reg_addr(RG_TXCK);
      data = 8'(1 << BIT_TXINV) | {4'h0, pix_div};
    end else if (step == STEP_W'(STEP_LDIV)) begin
      addr = reg_addr(RG_LDIV);
      data = {2'b00, div_log2(lkd_div), 4'h0};
    end else if (step == STEP_W'(STEP_TGLO)) begin
      addr = reg_addr(RG_TGLO);
      data = lock_tgt[7:0];
    end else if (step == STEP_W'(STEP_TGHI)) begin
      addr = reg_addr(RG_TGHI);
      data = {4'd2, 3'd2, lock_tgt[8]};
    end else begin
      addr = reg_addr(RG_MODE);
      data = 8'(1 << BIT_MDONE) | 8'(1 << BIT_ALIGN);
    end
  end

endmodule

// File: rtl/phy_cfg_poll_timer.sv
module phy_cfg_poll_timer #(
  parameter int POLL_CYC  = 6250,
  parameter int MAX_POLLS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic run,
  input  logic chk,
  output logic gap_over,
  output logic last_poll
);

  localparam int TW = $clog2(POLL_CYC + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  // read + check cycles are part of the spacing
  localparam logic [TW-1:0] GAP_LOAD = TW'(POLL_CYC - 3);

  logic [TW-1:0] gap_q, gap_d;
  logic          gap_en;
  logic [PW-1:0] polls_q, polls_d;
  logic          polls_en;

  always_comb begin
    gap_en = load | (run & (gap_q != '0));
    gap_d  = load ? GAP_LOAD : gap_q - TW'(1);
  end

  always_comb begin
    polls_en = clr | chk;
    polls_d  = clr ? '0 : polls_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (gap_en) gap_q <= gap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        polls_q <= '0;
    else if (polls_en) polls_q <= polls_d;
  end

  assign gap_over  = (gap_q == '0);
  assign last_poll = (polls_q == PW'(MAX_POLLS - 1));

  // R11
  poll_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk |-> (polls_q < PW'(MAX_POLLS)));

endmodule

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
  import phy_cfg_pkg::*;
#(
  parameter int CLK_KHZ    = 125000,
  parameter int POLL_US    = 50,
  parameter int TIMEOUT_US = 20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:0] pll_div,
  input  logic [3:0]  pix_div,
  input  logic [3:0]  lkd_div,
  input  logic [8:0]  lock_tgt,
  output logic        bus_wr,
  output logic        bus_rd,
  output logic [7:0]  bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  output logic        done,
  output logic        lock_error
);

  localparam int POLL_CYC  = CLK_KHZ * POLL_US / 1000;
  localparam int MAX_POLLS = TIMEOUT_US / POLL_US;

  logic rst_n_s;

  phy_cfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sq_state_t         state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              cap_en;

  logic [47:0] pll_q;
  logic [3:0]  pix_q;
  logic [3:0]  lkd_q;
  logic [8:0]  tgt_q;

  logic        gap_over, last_poll;
  logic        tmr_load;
  logic [7:0]  prog_addr, prog_data;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    step_en  = 1'b0;
    done_d   = 1'b0;
    err_d    = err_q;
    cap_en   = 1'b0;
    tmr_load = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_WRITE;
          step_d  = '0;
          step_en = 1'b1;
          err_d   = 1'b0;
          cap_en  = 1'b1;
        end
      end
      SQ_WRITE: begin
        if (step_q == STEP_W'(N_STEPS - 1)) begin
          state_d = SQ_READ;
        end else begin
          step_d  = step_q + STEP_W'(1);
          step_en = 1'b1;
        end
      end
      SQ_READ:  state_d = SQ_CHECK;
      SQ_CHECK: begin
        if (bus_rdata[BIT_LOCK]) begin
          state_d = SQ_IDLE;
          done_d  = 1'b1;
        end else if (last_poll) begin
          state_d = SQ_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
        end else begin
          state_d  = SQ_WAIT;
          tmr_load = 1'b1;
        end
      end
      SQ_WAIT: begin
        if (gap_over) state_d = SQ_READ;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pll_q <= '0;
      pix_q <= '0;
      lkd_q <= '0;
      tgt_q <= '0;
    end else if (cap_en) begin
      pll_q <= pll_div;
      pix_q <= pix_div;
      lkd_q <= lkd_div;
      tgt_q <= lock_tgt;
    end
  end

  phy_cfg_wr_prog u_prog (
    .step     (step_q),
    .pll_div  (pll_q),
    .pix_div  (pix_q),
    .lkd_div  (lkd_q),
    .lock_tgt (tgt_q),
    .addr     (prog_addr),
    .data     (prog_data)
  );

  phy_cfg_poll_timer #(
    .POLL_CYC  (POLL_CYC),
    .MAX_POLLS (MAX_POLLS)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (cap_en),
    .load      (tmr_load),
    .run       (state_q == SQ_WAIT),
    .chk       (state_q == SQ_CHECK),
    .gap_over  (gap_over),
    .last_poll (last_poll)
  );

  assign bus_wr     = (state_q == SQ_WRITE);
  assign bus_rd     = (state_q == SQ_READ);
  assign bus_addr   = bus_rd ? reg_addr(RG_STAT) : (bus_wr ? prog_addr : '0);
  assign bus_wdata  = bus_wr ? prog_data : '0;
  assign done       = done_q;
  assign lock_error = err_q;

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(bus_wr && bus_rd));

  // R9
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_rd |=> !bus_rd);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  // R10
  done_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(done) |-> $past(bus_rd, 2));

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(lock_error) |-> done);

endmodule

// File: tb/phy_cfg_seq_bench.sv
module phy_cfg_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [47:0] pll_div;
  logic [3:0]  pix_div;
  logic [3:0]  lkd_div;
  logic [8:0]  lock_tgt;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr, bus_wdata;
  logic [7:0]  bus_rdata;
  logic        done, lock_error;

  localparam int PCYC  = 125;  // 125000 kHz * 1 us
  localparam int NPOLL = 8;    // 8 us / 1 us
  localparam int LAT0  = 52;

  always #4 clk = ~clk;

  phy_cfg_seq #(.CLK_KHZ(125000), .POLL_US(1), .TIMEOUT_US(8)) u_phy_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_div(pll_div),
    .pix_div(pix_div), .lkd_div(lkd_div), .lock_tgt(lock_tgt),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .lock_error(lock_error)
  );

  // PHY register model and bus log
  logic [7:0] mem [0:63];
  logic [7:0] wl_a [0:1023];
  logic [7:0] wl_d [0:1023];
  int         wl_c [0:1023];
  int         rl_c [0:255];
  int wcnt = 0, rcnt = 0, cyc = 0;
  int w0 = 0, r0 = 0, lock_after = 0;
  int n_chk = 0, n_fail = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_wr) begin
      mem[bus_addr[7:2]] <= bus_wdata;
      wl_a[wcnt] <= bus_addr;
      wl_d[wcnt] <= bus_wdata;
      wl_c[wcnt] <= cyc;
      wcnt <= wcnt + 1;
    end
    if (bus_rd) begin
      if (bus_addr == 8'h88)
        bus_rdata <= ((rcnt - r0) >= lock_after) ? 8'hE0 : 8'h20;
      else
        bus_rdata <= mem[bus_addr[7:2]];
      rl_c[rcnt] <= cyc;
      rcnt <= rcnt + 1;
    end
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc >= 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  // caller sits at posedge+1; start is sampled on the next edge
  task automatic start_pulse();
    w0 = wcnt;
    r0 = rcnt;
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  // returns edges from the start-sampling edge until done is seen
  task automatic wait_done(input int poke1, input int poke2, output int n);
    n = 0;
    while (n < 3000) begin
      @(posedge clk);
      n++;
      #1;
      start = (n == poke1 || n == poke2);
      if (done) break;
    end
    start = 1'b0;
    if (!done) chk_eq("R10 done never seen", n, -1);
  endtask

  task automatic set_cfg(input logic [47:0] p, input logic [3:0] x,
                         input logic [3:0] l, input logic [8:0] t);
    pll_div = p; pix_div = x; lkd_div = l; lock_tgt = t;
  endtask

  task automatic t_reset();
    chk_eq("R1 bus_wr", int'(bus_wr), 0);
    chk_eq("R1 bus_rd", int'(bus_rd), 0);
    chk_eq("R1 done", int'(done), 0);
    chk_eq("R1 lock_error", int'(lock_error), 0);
  endtask

  task automatic t_basic();
    int n;
    set_cfg(48'hA1B2C3D4E5F6, 4'h5, 4'b0100, 9'h1A5);
    lock_after = 0;
    start_pulse();
    set_cfg(48'h0, 4'h0, 4'h0, 9'h0);  // snapshot must already be taken
    wait_done(0, 0, n);
    chk_eq("R10 latency lock first read", n, LAT0);
    chk_eq("R10 lock_error", int'(lock_error), 0);
    @(posedge clk); #1;
    chk_eq("R10 done one cycle", int'(done), 0);
    chk_eq("R8 write count", wcnt - w0, 50);
    chk_eq("R2 first addr", int'(wl_a[w0]), 8'h84);
    chk_eq("R2 first data", int'(wl_d[w0]), 8'h02);
    chk_eq("R8 last addr", int'(wl_a[w0+49]), 8'h84);
    chk_eq("R8 last data", int'(wl_d[w0+49]), 8'h82);
    chk_eq("R8 consecutive", wl_c[w0+49] - wl_c[w0], 49);
    chk_eq("R3 table first addr", int'(wl_a[w0+1]), 8'h00);
    chk_eq("R3 table last addr", int'(wl_a[w0+38]), 8'hBC);
    chk_eq("R3 table last data", int'(wl_d[w0+38]), 8'h00);
    chk_eq("R3 reg1", int'(mem[1]), 8'hD1);
    chk_eq("R3 reg8", int'(mem[8]), 8'h4F);
    chk_eq("R3 reg11", int'(mem[11]), 8'h65);
    chk_eq("R3 reg41", int'(mem[41]), 8'hE0);
    chk_eq("R3 reg45", int'(mem[45]), 8'hF8);
    for (int i = 0; i < 6; i++) begin
      chk_eq("R4 pll addr", int'(wl_a[w0+39+i]), 4*(2+i));
      chk_eq("R4 pll data", int'(wl_d[w0+39+i]), int'(8'(48'hA1B2C3D4E5F6 >> (8*i))));
    end
    chk_eq("R5 reg21", int'(mem[21]), 8'h85);
    chk_eq("R6 reg12 div4", int'(mem[12]), 8'h20);
    chk_eq("R7 reg13", int'(mem[13]), 8'hA5);
    chk_eq("R7 reg14 bit8 set", int'(mem[14]), 8'h25);
    chk_eq("R8 reg33 final", int'(mem[33]), 8'h82);
  endtask

  task automatic t_fields_poll();
    int n;
    set_cfg(48'h0F1E2D3C4B5A, 4'hC, 4'b0001, 9'h03C);
    lock_after = 3;
    start_pulse();
    wait_done(0, 0, n);
    chk_eq("R10 latency lock fourth read", n, LAT0 + 3*PCYC);
    chk_eq("R9 read count", rcnt - r0, 4);
    chk_eq("R9 first read after last write", rl_c[r0] - wl_c[w0+49], 1);
    chk_eq("R9 read spacing", rl_c[r0+1] - rl_c[r0], PCYC);
    chk_eq("R9 read spacing last", rl_c[r0+3] - rl_c[r0+2], PCYC);
    chk_eq("R5 reg21", int'(mem[21]), 8'h8C);
    chk_eq("R6 reg12 div1", int'(mem[12]), 8'h00);
    chk_eq("R7 reg13", int'(mem[13]), 8'h3C);
    chk_eq("R7 reg14 bit8 clear", int'(mem[14]), 8'h24);
    chk_eq("R4 reg2", int'(mem[2]), 8'h5A);
    chk_eq("R4 reg7", int'(mem[7]), 8'h0F);
  endtask

  task automatic t_timeout();
    int n;
    set_cfg(48'h1, 4'h1, 4'b1000, 9'h0);
    lock_after = 1000;
    start_pulse();
    wait_done(0, 0, n);
    chk_eq("R11 timeout latency", n, LAT0 + (NPOLL-1)*PCYC);
    chk_eq("R11 lock_error with done", int'(lock_error), 1);
    chk_eq("R11 reads before timeout", rcnt - r0, NPOLL);
    chk_eq("R6 reg12 div8", int'(mem[12]), 8'h30);
    repeat (20) @(posedge clk);
    #1 chk_eq("R11 lock_error held", int'(lock_error), 1);
    chk_eq("R11 no read after timeout", rcnt - r0, NPOLL);
  endtask

  task automatic t_last_poll();
    int n;
    lock_after = NPOLL - 1;
    start_pulse();
    chk_eq("R11 lock_error cleared by start", int'(lock_error), 0);
    wait_done(0, 0, n);
    chk_eq("R11 lock on last read latency", n, LAT0 + (NPOLL-1)*PCYC);
    chk_eq("R11 lock on last read is success", int'(lock_error), 0);
  endtask

  task automatic t_busy_start();
    int n;
    int wsave;
    lock_after = 2;
    start_pulse();
    wait_done(10, 200, n);
    chk_eq("R12 busy start latency", n, LAT0 + 2*PCYC);
    chk_eq("R12 busy start write count", wcnt - w0, 50);
    wsave = wcnt;
    repeat (150) begin
      @(posedge clk); #1;
      if (done) chk_eq("R12 extra done", 1, 0);
    end
    chk_eq("R12 no restart", wcnt - wsave, 0);
  endtask

  task automatic t_back_to_back();
    int n;
    lock_after = 0;
    start_pulse();
    wait_done(0, 0, n);
    chk_eq("R12 first run latency", n, LAT0);
    start_pulse();  // raised in the done cycle
    wait_done(0, 0, n);
    chk_eq("R12 restart in done cycle latency", n, LAT0);
    chk_eq("R12 restart write count", wcnt - w0, 50);
    chk_eq("R12 restart first write", int'(wl_a[w0]), 8'h84);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    set_cfg(48'h0, 4'h0, 4'h1, 9'h0);
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1 t_reset();
    t_basic();
    t_fields_poll();
    t_timeout();
    t_last_poll();
    t_busy_start();
    t_back_to_back();
    finish_run();
  end

endmodule